// File: doc/BRIEF.md
# Instruction Fetch Cache Controller

This block is a small direct-mapped cache placed between a processor fetch port and the read port of an on-chip flash array. The processor presents a word address with a valid/ready handshake, plus two qualifiers: whether the access is made from interrupt context and whether it is a plain data read rather than an instruction or vector fetch. The block answers with a one-cycle response pulse that carries the data word. On a miss it refills a whole line from the flash port, which has variable latency and answers each word request with an acknowledge pulse.

Three static control inputs shape the behaviour. One turns the cache off, so every access goes to flash as a single word. A second stops fetches made in interrupt context from allocating lines and from moving the counters. A third keeps the contents when the flash is written or a page is erased; otherwise such an event flushes every line. Two saturating counters report hits and line refills.

The controller is a four-state machine. IDLE accepts a request and looks it up. From IDLE: a hit goes to REPLY, an uncached access goes to PASS, and an allocating miss goes to FILL. FILL fetches the four words of the line and goes to REPLY after the last acknowledge. PASS fetches one word and goes to REPLY on its acknowledge. REPLY drives the response for one cycle and always returns to IDLE.

Top module: `ifetch_cache`

## Requirements
- R1: After reset both counters read 0, no line is valid, `req_ready` is 1, and `rsp_valid` and `fl_req` are 0.
- R2: A request whose line is valid with a matching tag returns the stored word on `rsp_data` with `rsp_valid` high in the cycle after acceptance, and makes no flash access.
- R3: The address is a word address. Bits [1:0] select the word in the line, bits [5:2] select one of 16 lines, and the upper bits form the tag. An allocating miss reads flash words 0,1,2,3 of the line in that order, then marks the line valid and returns the requested word.
- R4: While `cfg_cache_off` is 1, every request makes exactly one flash read at its own address, allocates nothing, and leaves both counters unchanged.
- R5: While `cfg_irq_noalloc` is 1, a fetch with `req_irq`=1 and `req_data`=0 is still looked up and hits return cached data. A miss of such a fetch is served by one single-word flash read and allocates no line. A data read with `req_irq`=1 allocates as usual.
- R6: While `cfg_irq_noalloc` is 1, fetches with `req_irq`=1 and `req_data`=0 move neither counter. When it is 0, interrupt-context fetches allocate and are counted.
- R7: `hit_count` grows by one per counted hit, and `miss_count` grows by one per line refill. Each holds at its all-ones value.
- R8: With `cfg_keep_on_write` at 0, a pulse on `ev_flash_write` or `ev_page_erase` makes every line invalid.
- R9: With `cfg_keep_on_write` at 1, such pulses leave the contents untouched, so later hits return the words cached earlier.
- R10: A flush that occurs while a line is being refilled leaves that line invalid once the refill ends, and the same address misses again.
- R11: `rsp_valid` is high for exactly one cycle per request. `fl_req` and `fl_addr` stay stable until `fl_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle (IDLE) |
| req_addr | input | ADDR_W | Word address |
| req_irq | input | 1 | Access made in interrupt context |
| req_data | input | 1 | 1 = data read, 0 = instruction or vector fetch |
| rsp_valid | output | 1 | Response pulse |
| rsp_data | output | DATA_W | Response word |
| fl_req | output | 1 | Flash word read request, held until acknowledged |
| fl_addr | output | ADDR_W | Flash word address |
| fl_ack | input | 1 | Flash read done pulse |
| fl_rdata | input | DATA_W | Flash word, valid with `fl_ack` |
| cfg_cache_off | input | 1 | Bypass the cache entirely |
| cfg_irq_noalloc | input | 1 | No allocation or counting for interrupt-context fetches |
| cfg_keep_on_write | input | 1 | Do not flush on flash write or erase |
| ev_flash_write | input | 1 | Flash word written (pulse) |
| ev_page_erase | input | 1 | Flash page erased (pulse) |
| hit_count | output | CNT_W | Saturating hit counter |
| miss_count | output | CNT_W | Saturating refill counter |

## Verification
The assertions assume that the flash port sends `fl_ack` only while `fl_req` is high, and at most once per word request. They also assume that the control inputs change only while the block is in IDLE. The bench's flash model acknowledges only an outstanding request, with a latency of zero to three cycles taken from the low address bits. The bench changes the controls only between requests, when no response is pending. Flush pulses are the one input that arrives during a refill, and the bench applies them there on purpose.

// File: rtl/icache_pkg.sv
package icache_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FILL,
        ST_PASS,
        ST_REPLY
    } icache_state_e;
endpackage

// File: rtl/icache_store.sv
module icache_store #(
    parameter int DATA_W = 32,
    parameter int OFF_W  = 2,
    parameter int IDX_W  = 4,
    parameter int TAG_W  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  lk_idx,
    input  logic [TAG_W-1:0]  lk_tag,
    input  logic [OFF_W-1:0]  lk_off,
    output logic              lk_hit,
    output logic [DATA_W-1:0] lk_data,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [OFF_W-1:0]  wr_off,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              seal_en,
    input  logic [TAG_W-1:0]  seal_tag,
    input  logic              flush
);
    localparam int LINES = 1 << IDX_W;
    localparam int WORDS = LINES << OFF_W;

    logic [LINES-1:0]  valid_q;
    logic [TAG_W-1:0]  tag_q  [LINES];
    logic [DATA_W-1:0] word_q [WORDS];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            for (int i = 0; i < LINES; i++) tag_q[i] <= '0;
        end else if (flush) begin
            valid_q <= '0;
        end else if (seal_en) begin
            valid_q[wr_idx] <= 1'b1;
            tag_q[wr_idx]   <= seal_tag;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) word_q[{wr_idx, wr_off}] <= wr_data;
    end

    assign lk_hit  = valid_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
    assign lk_data = word_q[{lk_idx, lk_off}];

    // Flush wins over a simultaneous seal.
    assert_flush_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (valid_q == '0));
    assert_seal_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (seal_en && !flush) |=> valid_q[$past(wr_idx)]);
endmodule

// File: rtl/icache_satcnt.sv
module icache_satcnt #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);
    always_ff @(posedge clk) begin
        if (!rst_n)                   count <= '0;
        else if (inc && count != '1)  count <= count + 1'b1;
    end

    assert_sat_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (count == '1) |=> (count == '1));
    assert_step_one_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (count == $past(count)) || (count == $past(count) + 1'b1));
endmodule

// File: rtl/icache_ctrl.sv
module icache_ctrl
    import icache_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int OFF_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_irq,
    input  logic              req_data,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic              fl_req,
    output logic [ADDR_W-1:0] fl_addr,
    input  logic              fl_ack,
    input  logic [DATA_W-1:0] fl_rdata,
    input  logic              cfg_off,
    input  logic              cfg_noalloc,
    input  logic              flush,
    input  logic              lk_hit,
    input  logic [DATA_W-1:0] lk_data,
    output logic [ADDR_W-1:0] line_addr,
    output logic [OFF_W-1:0]  fill_off,
    output logic              wr_en,
    output logic              seal_en,
    output logic              hit_inc,
    output logic              miss_inc
);
    icache_state_e     state_q, state_d;
    logic [ADDR_W-1:0] addr_q;
    logic [OFF_W-1:0]  fill_q;
    logic              kill_q;
    logic [DATA_W-1:0] rsp_q;
    logic              quiet;

    assign quiet     = req_irq && cfg_noalloc && !req_data;
    assign line_addr = addr_q;
    assign fill_off  = fill_q;
    assign rsp_data  = rsp_q;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d   = state_q;
        req_ready = 1'b0;
        rsp_valid = 1'b0;
        fl_req    = 1'b0;
        fl_addr   = addr_q;
        wr_en     = 1'b0;
        seal_en   = 1'b0;
        hit_inc   = 1'b0;
        miss_inc  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                req_ready = 1'b1;
                if (req_valid) begin
                    if (!cfg_off && lk_hit) begin
                        state_d = ST_REPLY;
                        hit_inc = !quiet;
                    end else if (cfg_off || quiet) begin
                        state_d = ST_PASS;
                    end else begin
                        state_d  = ST_FILL;
                        miss_inc = 1'b1;
                    end
                end
            end
            ST_FILL: begin
                fl_req  = 1'b1;
                fl_addr = {addr_q[ADDR_W-1:OFF_W], fill_q};
                if (fl_ack) begin
                    wr_en = 1'b1;
                    if (fill_q == '1) begin
                        seal_en = !(kill_q || flush);
                        state_d = ST_REPLY;
                    end
                end
            end
            ST_PASS: begin
                fl_req = 1'b1;
                if (fl_ack) state_d = ST_REPLY;
            end
            ST_REPLY: begin
                rsp_valid = 1'b1;
                state_d   = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            fill_q <= '0;
            kill_q <= 1'b0;
            rsp_q  <= '0;
        end else begin
            if (state_q == ST_IDLE && req_valid) begin
                addr_q <= req_addr;
                fill_q <= '0;
                kill_q <= flush;
                if (!cfg_off && lk_hit) rsp_q <= lk_data;
            end
            if (state_q == ST_FILL) begin
                if (flush) kill_q <= 1'b1;
                if (fl_ack) begin
                    fill_q <= fill_q + 1'b1;
                    if (fill_q == addr_q[OFF_W-1:0]) rsp_q <= fl_rdata;
                end
            end
            if (state_q == ST_PASS && fl_ack) rsp_q <= fl_rdata;
        end
    end

    assert_reply_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
    assert_flash_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_req && !fl_ack) |=> (fl_req && $stable(fl_addr)));
    assert_fill_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FILL && fl_ack && fl_addr[OFF_W-1:0] != '1)
        |=> (fl_req && fl_addr[OFF_W-1:0] == $past(fl_addr[OFF_W-1:0]) + 1'b1));
endmodule

// File: rtl/ifetch_cache.sv
module ifetch_cache #(
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 32,
    parameter int LINES      = 16,
    parameter int LINE_WORDS = 4,
    parameter int CNT_W      = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_irq,
    input  logic              req_data,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic              fl_req,
    output logic [ADDR_W-1:0] fl_addr,
    input  logic              fl_ack,
    input  logic [DATA_W-1:0] fl_rdata,
    input  logic              cfg_cache_off,
    input  logic              cfg_irq_noalloc,
    input  logic              cfg_keep_on_write,
    input  logic              ev_flash_write,
    input  logic              ev_page_erase,
    output logic [CNT_W-1:0]  hit_count,
    output logic [CNT_W-1:0]  miss_count
);
    localparam int OFF_W = $clog2(LINE_WORDS);
    localparam int IDX_W = $clog2(LINES);
    localparam int TAG_W = ADDR_W - OFF_W - IDX_W;

    logic              flush;
    logic              lk_hit;
    logic [DATA_W-1:0] lk_data;
    logic [ADDR_W-1:0] line_addr;
    logic [OFF_W-1:0]  fill_off;
    logic              wr_en, seal_en;
    logic [1:0]        cnt_inc;
    logic [CNT_W-1:0]  cnt_val [2];

    assign flush = (ev_flash_write || ev_page_erase) && !cfg_keep_on_write;

    icache_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFF_W(OFF_W)) u_ctrl (
        .clk, .rst_n, .req_valid, .req_ready, .req_addr, .req_irq, .req_data,
        .rsp_valid, .rsp_data, .fl_req, .fl_addr, .fl_ack, .fl_rdata,
        .cfg_off(cfg_cache_off), .cfg_noalloc(cfg_irq_noalloc), .flush,
        .lk_hit, .lk_data, .line_addr, .fill_off, .wr_en, .seal_en,
        .hit_inc(cnt_inc[0]), .miss_inc(cnt_inc[1])
    );

    icache_store #(.DATA_W(DATA_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_store (
        .clk, .rst_n,
        .lk_idx(req_addr[OFF_W +: IDX_W]),
        .lk_tag(req_addr[ADDR_W-1 -: TAG_W]),
        .lk_off(req_addr[OFF_W-1:0]),
        .lk_hit, .lk_data,
        .wr_en,
        .wr_idx(line_addr[OFF_W +: IDX_W]),
        .wr_off(fill_off),
        .wr_data(fl_rdata),
        .seal_en,
        .seal_tag(line_addr[ADDR_W-1 -: TAG_W]),
        .flush
    );

    for (genvar k = 0; k < 2; k++) begin : g_cnt
        icache_satcnt #(.CNT_W(CNT_W)) u_cnt (
            .clk, .rst_n, .inc(cnt_inc[k]), .count(cnt_val[k])
        );
    end

    assign hit_count  = cnt_val[0];
    assign miss_count = cnt_val[1];

    assert_off_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cfg_cache_off) |-> ($stable(hit_count) && $stable(miss_count)));
    assert_irq_uncounted_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(req_valid && req_ready && req_irq && cfg_irq_noalloc && !req_data)
        |-> ($stable(hit_count) && $stable(miss_count)));
    assert_idle_no_flash_R1: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !fl_req);
endmodule

// File: tb/ifetch_cache_tb.sv
module ifetch_cache_tb;
    localparam int AW = 16;
    localparam int DW = 32;
    localparam int CW = 8;
    localparam int NV = 12;
    // {addr[20:5], irq[4], data_read[3], expected flash acks[2:0]}
    localparam logic [20:0] VEC [NV] = '{
        {16'h0040, 1'b0, 1'b0, 3'd4}, {16'h0041, 1'b0, 1'b0, 3'd0},
        {16'h0043, 1'b0, 1'b0, 3'd0}, {16'h0104, 1'b1, 1'b0, 3'd1},
        {16'h0104, 1'b0, 1'b0, 3'd4}, {16'h0106, 1'b1, 1'b0, 3'd0},
        {16'h0080, 1'b0, 1'b0, 3'd4}, {16'h0040, 1'b1, 1'b0, 3'd1},
        {16'h0042, 1'b0, 1'b0, 3'd4}, {16'h0105, 1'b0, 1'b0, 3'd0},
        {16'h0200, 1'b1, 1'b1, 3'd4}, {16'h0201, 1'b0, 1'b0, 3'd0}
    };

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_irq = 1'b0, req_data = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic req_ready, rsp_valid, fl_req;
    logic [DW-1:0] rsp_data;
    logic [AW-1:0] fl_addr;
    logic fl_ack;
    logic [DW-1:0] fl_rdata;
    logic cfg_cache_off = 1'b0, cfg_irq_noalloc = 1'b0, cfg_keep_on_write = 1'b0;
    logic ev_flash_write = 1'b0, ev_page_erase = 1'b0;
    logic [CW-1:0] hit_count, miss_count;

    int gen = 0;
    int total = 0, bad = 0;
    int nack;
    logic [1:0] lat;
    logic [AW-1:0] acklog [8];

    ifetch_cache #(.ADDR_W(AW), .DATA_W(DW), .CNT_W(CW)) u_dut (
        .clk, .rst_n, .req_valid, .req_ready, .req_addr, .req_irq, .req_data,
        .rsp_valid, .rsp_data, .fl_req, .fl_addr, .fl_ack, .fl_rdata,
        .cfg_cache_off, .cfg_irq_noalloc, .cfg_keep_on_write,
        .ev_flash_write, .ev_page_erase, .hit_count, .miss_count
    );

    function automatic logic [DW-1:0] model(logic [AW-1:0] a, int g);
        return {a, a ^ 16'h5A3C} ^ (32'(g) * 32'h0103_0507);
    endfunction

    // Flash model: latency 0..3 cycles from the low address bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat <= '0; fl_ack <= 1'b0; fl_rdata <= '0; nack <= 0;
        end else begin
            fl_ack <= 1'b0;
            if (fl_req && !fl_ack) begin
                if (lat >= fl_addr[1:0]) begin
                    fl_ack <= 1'b1;
                    fl_rdata <= model(fl_addr, gen);
                    lat <= '0;
                    acklog[nack % 8] <= fl_addr;
                    nack <= nack + 1;
                end else begin
                    lat <= lat + 1'b1;
                end
            end
        end
    end

    task automatic check(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_req(input logic [AW-1:0] a, input logic irq, input logic dat,
                          output logic [DW-1:0] data, output int acks);
        int n0, cnt;
        @(negedge clk);
        n0 = nack;
        req_addr = a; req_irq = irq; req_data = dat; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        cnt = 0;
        while (!rsp_valid && cnt < 100) begin @(negedge clk); cnt++; end
        data = rsp_data;
        acks = nack - n0;
        @(negedge clk);
        check(!rsp_valid, "R11 response lasts one cycle", 32'(rsp_valid), 0);
    endtask

    task automatic pulse(input bit erase);
        @(negedge clk);
        if (erase) ev_page_erase = 1'b1; else ev_flash_write = 1'b1;
        @(negedge clk);
        ev_page_erase = 1'b0; ev_flash_write = 1'b0;
        gen++;
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #(20 * 100000);
        total++; bad++;
        $display("FAIL watchdog expired actual=%h expected=%h", 0, 1);
        finish_run();
    end

    initial begin
        logic [DW-1:0] d;
        int acks;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(hit_count == 0 && miss_count == 0, "R1 counters zero", {hit_count, miss_count}, 0);
        check(req_ready && !rsp_valid && !fl_req, "R1 idle outputs",
              {req_ready, rsp_valid, fl_req}, 3'b100);

        // R2 R3 R5 R6: table walk with interrupt allocation disabled
        cfg_irq_noalloc = 1'b1;
        for (int i = 0; i < NV; i++) begin
            do_req(VEC[i][20:5], VEC[i][4], VEC[i][3], d, acks);
            check(d == model(VEC[i][20:5], gen), "R2/R3/R5 data", d, model(VEC[i][20:5], gen));
            check(acks == int'(VEC[i][2:0]), "R5 flash accesses (R2 hit = 0, R3 fill = 4)",
                  acks, VEC[i][2:0]);
        end
        check(hit_count == 4, "R6 hit count after irq mix", hit_count, 4);
        check(miss_count == 5, "R6 miss count after irq mix", miss_count, 5);

        // R8 write flushes
        pulse(1'b0);
        do_req(16'h0201, 1'b0, 1'b0, d, acks);
        check(acks == 4, "R8 miss after write", acks, 4);
        check(d == model(16'h0201, gen), "R8 fresh data", d, model(16'h0201, gen));
        check(miss_count == 6, "R8 miss count", miss_count, 6);

        // R9 keep contents across erase
        cfg_keep_on_write = 1'b1;
        pulse(1'b1);
        do_req(16'h0202, 1'b0, 1'b0, d, acks);
        check(acks == 0, "R9 hit after kept erase", acks, 0);
        check(d == model(16'h0202, gen - 1), "R9 stale data kept", d, model(16'h0202, gen - 1));
        check(hit_count == 5, "R9 hit count", hit_count, 5);
        cfg_keep_on_write = 1'b0;

        // R4 cache off
        cfg_cache_off = 1'b1;
        do_req(16'h0201, 1'b0, 1'b0, d, acks);
        check(acks == 1, "R4 single flash read", acks, 1);
        check(d == model(16'h0201, gen), "R4 flash data", d, model(16'h0201, gen));
        check(hit_count == 5 && miss_count == 6, "R4 counters unchanged",
              {hit_count, miss_count}, {8'd5, 8'd6});
        cfg_cache_off = 1'b0;

        // R6 irq fetch allocates and counts when the control is clear
        cfg_irq_noalloc = 1'b0;
        do_req(16'h0300, 1'b1, 1'b0, d, acks);
        check(acks == 4 && miss_count == 7, "R6 irq refill counted", {acks[7:0], miss_count}, {8'd4, 8'd7});

        // R10 flush during a refill
        fork
            do_req(16'h0340, 1'b0, 1'b0, d, acks);
            begin repeat (4) @(negedge clk); pulse(1'b1); end
        join
        do_req(16'h0341, 1'b0, 1'b0, d, acks);
        check(acks == 4, "R10 line not valid after flushed refill", acks, 4);
        check(d == model(16'h0341, gen), "R10 data", d, model(16'h0341, gen));

        // R3 refill order
        do_req(16'h00C1, 1'b0, 1'b0, d, acks);
        for (int k = 0; k < 4; k++)
            check(acklog[(nack - 4 + k) % 8] == 16'h00C0 + AW'(k), "R3 refill order",
                  acklog[(nack - 4 + k) % 8], 16'h00C0 + AW'(k));
        check(miss_count == 10, "R7 miss count", miss_count, 10);

        // R7 saturation
        for (int k = 0; k < 260; k++) do_req(16'h00C2, 1'b0, 1'b0, d, acks);
        check(hit_count == 8'hFF, "R7 hit counter saturates", hit_count, 8'hFF);
        check(d == model(16'h00C2, gen), "R2 hit data", d, model(16'h00C2, gen));
        finish_run();
    end
endmodule